// File: doc/BRIEF.md
# NAND Device Bus Front End

This block is the device-side bus logic of a byte/word NAND-style memory. It samples a multiplexed 16-bit I/O bus together with chip select, command strobe, address strobe, write strobe and read strobe, all active as in a conventional NAND pin-out. It then steers each write cycle to one of three places: the command decoder, the address collector or the page data path. All strobes are sampled on the system clock. A write cycle takes effect on the clock edge where the write strobe is first seen high after being low. A read cycle takes effect on the edge where the read strobe is first seen low after being high.

A small behavioural page buffer and a busy timer stand in for the memory core. They make the program, read and erase sequences observable. The block drives an open-drain ready/busy indication (`rb_pull_low` high means the pin is pulled low), honours an active-low write-protect input, answers a status query, and flags a protocol error when the upper bus half is non-zero during a command or address cycle in 16-bit mode.

Top module: `nand_bus_front`

## Requirements
- R1: A command is taken from `io_in[7:0]` on a write-strobe rising edge when `cle`=1, `ale`=0 and `ce_n`=0. The codes are 00h read setup, 30h read start, 80h program setup, 10h program start, 60h erase setup, D0h erase start, 70h status, FFh reset. Other codes are ignored.
- R2: Address cycles (`ale`=1, `cle`=0, `ce_n`=0, rising write strobe) are counted. The first COL_CYC bytes form the column and load the column counter, whose low COL_W bits are used. The next ROW_CYC bytes form `row_addr`, lowest byte first. Cycles beyond that total are ignored, and any accepted command restarts the count.
- R3: After program setup, each data cycle (`ale`=0, `cle`=0) writes one word to the page buffer at the column counter and then increments the counter. In 8-bit mode (`wide_mode`=0) the upper byte is stored as zero.
- R4: Each falling read strobe while ready, selected and in data mode places the page word at the column counter on `io_out` one clock later and increments the counter, which wraps modulo the page size. In 8-bit mode `io_out[15:8]` reads zero.
- R5: A start command (30h, 10h, D0h) that follows its matching setup raises `rb_pull_low` for exactly T_READ, T_PROG or T_ERASE clocks respectively, beginning with the clock after the command edge.
- R6: While busy, `ce_n` has no effect. Raising it neither shortens the busy time nor asserts `standby`. When ready, `standby` equals `ce_n`.
- R7: In 16-bit mode, a command or address cycle with `io_in[15:8]` non-zero raises `proto_err` for one clock and is otherwise dropped. In 8-bit mode those bits are not checked.
- R8: With `wp_n`=0, program setup and erase setup are rejected. The fail flag is set, no busy period starts, and the following data and start commands do not alter the page buffer.
- R9: An FFh command ends any busy period within one clock, even with `ce_n` high, and also clears the fail flag and returns to data mode.
- R10: After 70h (accepted even while busy and with `ce_n` high), `io_out` shows `{8'h00, wp_n, ready, 5'b0, fail}`: bit 7 is write-protect, bit 6 is ready and bit 0 is fail. Read setup (00h), read start (30h) and FFh return to data mode.
- R11: A write cycle with `cle` and `ale` both high is ignored.
- R12: `io_oe` is high only when `ce_n`=0, `re_n`=0 and the block is either ready or in status mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command strobe qualifier |
| ale | input | 1 | Address strobe qualifier |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| io_in | input | 16 | Bus value driven into the device |
| io_out | output | 16 | Bus value driven by the device |
| io_oe | output | 1 | Output enable for `io_out` |
| rb_pull_low | output | 1 | Open-drain ready/busy: 1 pulls the pin low (busy) |
| standby | output | 1 | Low-power standby indication |
| proto_err | output | 1 | One-clock pulse on an illegal upper-byte cycle |
| row_addr | output | 8*ROW_CYC | Collected row address |

## Verification
Every bus cycle resolves on the clock edge where the strobe transition is first sampled. Command, address and data effects, `proto_err` and the start of busy are therefore all visible one clock after that edge. The bench drives each strobe phase across a full clock, starting from the falling clock edge, and samples right after the resolving edge. The busy length is measured by counting falling-edge samples with `rb_pull_low` high, starting at the first one after the start command, and that count must equal the configured duration exactly. Read data is sampled one falling edge after the read strobe goes low, which is the clock in which the registered word appears.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RD_ADDR,
        PH_PG_LOAD,
        PH_ER_ADDR
    } phase_e;

    localparam logic [7:0] OP_READ     = 8'h00;
    localparam logic [7:0] OP_READ_GO  = 8'h30;
    localparam logic [7:0] OP_PROG     = 8'h80;
    localparam logic [7:0] OP_PROG_GO  = 8'h10;
    localparam logic [7:0] OP_ERASE    = 8'h60;
    localparam logic [7:0] OP_ERASE_GO = 8'hD0;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_RESET    = 8'hFF;

endpackage

// File: rtl/nfe_strobe.sv
// Samples one strobe pin and reports a single chosen transition.
module nfe_strobe #(
    parameter bit IDLE_LEVEL  = 1'b1,
    parameter bit DETECT_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_seen
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = pin;
        if (DETECT_RISE) edge_seen = !lvl_q && pin;
        else             edge_seen = lvl_q && !pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= IDLE_LEVEL;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/nfe_busy_timer.sv
// Counts down an operation duration; can be cut short.
module nfe_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dur,
    input  logic             abort,
    output logic             busy
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = dur - 1'b1;
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    // chip select plays no part here: only the count or an abort ends busy
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !abort && s_q.cnt != '0) |=> s_q.busy);

    assert_abort_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);
endmodule

// File: rtl/nfe_page_buf.sv
// Behavioural single-page store standing in for the array.
module nfe_page_buf #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_d [WORDS];
    logic [DW-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
    import nfe_pkg::*;
#(
    parameter int COL_W   = 4,
    parameter int COL_CYC = 1,
    parameter int ROW_CYC = 2,
    parameter int T_READ  = 6,
    parameter int T_PROG  = 9,
    parameter int T_ERASE = 12,
    parameter int TMR_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 cle,
    input  logic                 ale,
    input  logic                 we_n,
    input  logic                 re_n,
    input  logic                 wp_n,
    input  logic                 wide_mode,
    input  logic [15:0]          io_in,
    output logic [15:0]          io_out,
    output logic                 io_oe,
    output logic                 rb_pull_low,
    output logic                 standby,
    output logic                 proto_err,
    output logic [8*ROW_CYC-1:0] row_addr
);
    localparam int ADDR_CYC = COL_CYC + ROW_CYC;
    localparam int CNT_W    = $clog2(ADDR_CYC + 1);
    localparam int ROW_W    = 8 * ROW_CYC;
    localparam int CB_W     = 8 * COL_CYC;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_CYC);
    localparam logic [COL_W-1:0] COL_ONE  = COL_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] acnt;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             status_mode;
        logic             fail;
        logic [15:0]      dout;
        logic             perr;
    } ctl_t;

    ctl_t s_d, s_q;

    logic we_rise, re_fall, busy;
    logic bad_hi, cmd_evt, addr_evt, data_evt;
    logic tmr_start, tmr_abort;
    logic [TMR_W-1:0] tmr_dur;
    logic pb_wr;
    logic [15:0] pb_wdata, pb_rdata;
    logic [CB_W-1:0] cwide;
    int idx;

    nfe_strobe #(.IDLE_LEVEL(1'b1), .DETECT_RISE(1'b1)) u_we (
        .clk(clk), .rst_n(rst_n), .pin(we_n), .edge_seen(we_rise));

    nfe_strobe #(.IDLE_LEVEL(1'b1), .DETECT_RISE(1'b0)) u_re (
        .clk(clk), .rst_n(rst_n), .pin(re_n), .edge_seen(re_fall));

    nfe_busy_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .dur(tmr_dur),
        .abort(tmr_abort), .busy(busy));

    nfe_page_buf #(.AW(COL_W), .DW(16)) u_page (
        .clk(clk), .rst_n(rst_n), .wr_en(pb_wr), .wr_addr(s_q.col),
        .wr_data(pb_wdata), .rd_addr(s_q.col), .rd_data(pb_rdata));

    // cycle classification; chip select is bypassed for commands while busy
    assign bad_hi   = wide_mode && (io_in[15:8] != 8'h00);
    assign cmd_evt  = we_rise && cle && !ale && (busy || !ce_n);
    assign addr_evt = we_rise && ale && !cle && !ce_n && !busy;
    assign data_evt = we_rise && !ale && !cle && !ce_n && !busy;

    always_comb begin
        s_d       = s_q;
        s_d.perr  = 1'b0;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        tmr_dur   = '0;
        pb_wr     = 1'b0;
        pb_wdata  = wide_mode ? io_in : {8'h00, io_in[7:0]};
        cwide     = '0;
        idx       = 0;

        if ((cmd_evt || addr_evt) && bad_hi) begin
            s_d.perr = 1'b1;
        end else if (cmd_evt) begin
            s_d.acnt = '0;
            if (busy) begin
                if (io_in[7:0] == OP_RESET) begin
                    tmr_abort       = 1'b1;
                    s_d.phase       = PH_IDLE;
                    s_d.status_mode = 1'b0;
                    s_d.fail        = 1'b0;
                end else if (io_in[7:0] == OP_STATUS) begin
                    s_d.status_mode = 1'b1;
                end
            end else begin
                case (io_in[7:0])
                    OP_RESET: begin
                        s_d.phase       = PH_IDLE;
                        s_d.status_mode = 1'b0;
                        s_d.fail        = 1'b0;
                    end
                    OP_STATUS: s_d.status_mode = 1'b1;
                    OP_READ: begin
                        s_d.phase       = PH_RD_ADDR;
                        s_d.status_mode = 1'b0;
                    end
                    OP_READ_GO: begin
                        if (s_q.phase == PH_RD_ADDR) begin
                            tmr_start = 1'b1;
                            tmr_dur   = TMR_W'(T_READ);
                        end
                        s_d.phase       = PH_IDLE;
                        s_d.status_mode = 1'b0;
                    end
                    OP_PROG: begin
                        if (wp_n) begin
                            s_d.phase = PH_PG_LOAD;
                        end else begin
                            s_d.phase = PH_IDLE;
                            s_d.fail  = 1'b1;
                        end
                    end
                    OP_PROG_GO: begin
                        if (s_q.phase == PH_PG_LOAD) begin
                            tmr_start = 1'b1;
                            tmr_dur   = TMR_W'(T_PROG);
                        end
                        s_d.phase = PH_IDLE;
                    end
                    OP_ERASE: begin
                        if (wp_n) begin
                            s_d.phase = PH_ER_ADDR;
                        end else begin
                            s_d.phase = PH_IDLE;
                            s_d.fail  = 1'b1;
                        end
                    end
                    OP_ERASE_GO: begin
                        if (s_q.phase == PH_ER_ADDR) begin
                            tmr_start = 1'b1;
                            tmr_dur   = TMR_W'(T_ERASE);
                        end
                        s_d.phase = PH_IDLE;
                    end
                    default: ;
                endcase
            end
        end else if (addr_evt) begin
            if (s_q.acnt < CNT_LAST) begin
                idx = int'(s_q.acnt);
                if (idx < COL_CYC) begin
                    cwide = CB_W'(s_q.col);
                    cwide[idx*8 +: 8] = io_in[7:0];
                    s_d.col = COL_W'(cwide);
                end else begin
                    s_d.row[(idx - COL_CYC)*8 +: 8] = io_in[7:0];
                end
                s_d.acnt = s_q.acnt + 1'b1;
            end
        end else if (data_evt) begin
            if (s_q.phase == PH_PG_LOAD) begin
                pb_wr   = 1'b1;
                s_d.col = s_q.col + COL_ONE;
            end
        end else if (re_fall && !ce_n && !busy && !s_q.status_mode) begin
            s_d.dout = pb_rdata;
            s_d.col  = s_q.col + COL_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign io_out      = s_q.status_mode ? {8'h00, wp_n, !busy, 5'b00000, s_q.fail}
                       : (wide_mode ? s_q.dout : {8'h00, s_q.dout[7:0]});
    assign io_oe       = !ce_n && !re_n && (!busy || s_q.status_mode);
    assign rb_pull_low = busy;
    assign standby     = ce_n && !busy;
    assign proto_err   = s_q.perr;
    assign row_addr    = s_q.row;

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> rb_pull_low);

    assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && !we_rise && !ce_n && !busy && !s_q.status_mode)
        |=> (s_q.col == $past(s_q.col) + COL_ONE));

    assert_wp_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_evt && !bad_hi && !busy && io_in[7:0] == OP_PROG && !wp_n)
        |=> (s_q.phase == PH_IDLE && s_q.fail && !rb_pull_low));

    assert_perr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (row_addr == $past(row_addr) && !$rose(rb_pull_low)));

    assert_both_high_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && cle && ale)
        |=> (s_q.acnt == $past(s_q.acnt) && s_q.phase == $past(s_q.phase)));
endmodule

// File: tb/nand_bus_front_test.sv
`timescale 1ns/1ps
module nand_bus_front_test;
    localparam int T_READ  = 6;
    localparam int T_PROG  = 9;
    localparam int T_ERASE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic wp_n = 1'b1, wide_mode = 1'b1;
    logic [15:0] io_in = 16'h0000;
    logic [15:0] io_out;
    logic io_oe, rb_pull_low, standby, proto_err;
    logic [15:0] row_addr;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    logic [15:0] model [16];

    always #2 clk = ~clk;

    nand_bus_front uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .wide_mode(wide_mode),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .rb_pull_low(rb_pull_low), .standby(standby),
        .proto_err(proto_err), .row_addr(row_addr));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_cmd(input logic [7:0] b, input logic [7:0] hi = 8'h00);
        cle = 1'b1; ale = 1'b0; io_in = {hi, b}; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; io_in = 16'h0000;
    endtask

    task automatic bus_addr(input logic [7:0] b, input logic [7:0] hi = 8'h00);
        cle = 1'b0; ale = 1'b1; io_in = {hi, b}; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ale = 1'b0; io_in = 16'h0000;
    endtask

    task automatic bus_both(input logic [7:0] b);
        cle = 1'b1; ale = 1'b1; io_in = {8'h00, b}; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0; io_in = 16'h0000;
    endtask

    task automatic bus_data(input logic [15:0] w);
        cle = 1'b0; ale = 1'b0; io_in = w; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); io_in = 16'h0000;
    endtask

    task automatic bus_read(output logic [15:0] w, output logic oe);
        re_n = 1'b0;
        @(negedge clk); w = io_out; oe = io_oe;
        re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (rb_pull_low && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic open_read(input logic [7:0] col);
        int n;
        bus_cmd(8'h00);
        bus_addr(col); bus_addr(8'h11); bus_addr(8'h22);
        bus_cmd(8'h30);
        wait_ready(n);
        check("R5 read busy length", n, T_READ);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog: got %0d expected completion", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic oe;
        int n;
        for (int i = 0; i < 16; i++) model[i] = 16'h0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset ready", rb_pull_low, 0);
        check("R6 reset standby", standby, 1);
        check("R7 reset no error", proto_err, 0);
        check("R2 reset row", row_addr, 0);
        check("R12 reset oe", io_oe, 0);
        ce_n = 1'b0;
        @(negedge clk);
        check("R6 standby follows ce_n", standby, 0);

        // R1 R3 R5 R6: program sweep over every start column
        for (int s = 0; s < 16; s++) begin
            bus_cmd(8'h80);
            bus_addr(8'(s)); bus_addr(8'(s)); bus_addr(8'hA0);
            check("R2 row collect", row_addr, {8'hA0, 8'(s)});
            for (int k = 0; k < 3; k++) begin
                w = 16'((s * 257) ^ (k * 4369) ^ 23040);
                bus_data(w);
                model[(s + k) % 16] = w;
            end
            bus_cmd(8'h10);
            if (s == 5) begin
                ce_n = 1'b1;
                #0;
                check("R6 no standby while busy", standby, 0);
            end
            wait_ready(n);
            check("R5 program busy length", n, T_PROG);
            ce_n = 1'b0;
        end

        // R4 R12: full page read plus wrap
        open_read(8'h00);
        for (int i = 0; i < 17; i++) begin
            bus_read(w, oe);
            check("R4 page word", w, model[i % 16]);
            check("R12 oe during read", oe, 1);
        end
        open_read(8'd13);
        for (int i = 0; i < 4; i++) begin
            bus_read(w, oe);
            check("R4 wrap from col 13", w, model[(13 + i) % 16]);
        end

        // R3 R7: narrow bus stores low byte, upper bits unchecked
        wide_mode = 1'b0;
        bus_cmd(8'h80, 8'hFF);
        check("R7 narrow mode no error", proto_err, 0);
        bus_addr(8'h02); bus_addr(8'h00); bus_addr(8'h00);
        bus_data(16'hBEEF);
        model[2] = 16'h00EF;
        bus_cmd(8'h10);
        wait_ready(n);
        open_read(8'h02);
        bus_read(w, oe);
        check("R4 narrow read upper zero", w, 16'h00EF);
        wide_mode = 1'b1;
        open_read(8'h02);
        bus_read(w, oe);
        check("R3 narrow write stored", w, 16'h00EF);

        // R7: bad upper byte drops the cycle
        bus_cmd(8'h00);
        bus_addr(8'h03, 8'h01);
        check("R7 addr error pulse", proto_err, 1);
        @(negedge clk);
        check("R7 error one clock", proto_err, 0);
        bus_addr(8'h05); bus_addr(8'h01); bus_addr(8'h02);
        check("R7 dropped addr row", row_addr, 16'h0201);
        bus_cmd(8'h70, 8'h80);
        check("R7 cmd error pulse", proto_err, 1);
        bus_cmd(8'h30);
        wait_ready(n);
        check("R5 read after dropped cmd", n, T_READ);
        bus_read(w, oe);
        check("R7 column from next good addr", w, model[5]);

        // R11: both strobes high ignored
        bus_cmd(8'h00);
        bus_addr(8'h04);
        bus_both(8'h30);
        check("R11 no busy from both-high", rb_pull_low, 0);
        bus_addr(8'h00); bus_addr(8'h00);
        check("R11 row unchanged", row_addr, 16'h0000);
        bus_cmd(8'h30);
        wait_ready(n);
        bus_read(w, oe);
        check("R11 column kept", w, model[4]);

        // R2: extra address cycles and restart on command
        bus_cmd(8'h00);
        bus_addr(8'h01); bus_addr(8'h02); bus_addr(8'h03); bus_addr(8'h04);
        check("R2 extra addr ignored", row_addr, 16'h0302);
        bus_cmd(8'h00);
        bus_addr(8'h09); bus_addr(8'h44); bus_addr(8'h55);
        check("R2 count restarts", row_addr, 16'h5544);
        bus_cmd(8'h30);
        wait_ready(n);
        bus_read(w, oe);
        check("R2 restarted column", w, model[9]);

        // R8 R10: write protect
        wp_n = 1'b0;
        bus_cmd(8'h80);
        bus_addr(8'h00); bus_addr(8'h00); bus_addr(8'h00);
        bus_data(16'hDEAD);
        bus_cmd(8'h10);
        check("R8 no busy when protected", rb_pull_low, 0);
        bus_cmd(8'h70);
        bus_read(w, oe);
        check("R10 status fail protected", w, 16'h0041);
        wp_n = 1'b1;
        @(negedge clk);
        check("R10 status live wp bit", io_out, 16'h00C1);
        open_read(8'h00);
        bus_read(w, oe);
        check("R8 page unchanged", w, model[0]);

        // R9 R10 R12 R6: status and reset during erase
        bus_cmd(8'hFF);
        bus_cmd(8'h70);
        check("R9 fail cleared", io_out, 16'h00C0);
        bus_cmd(8'h60);
        bus_addr(8'h00); bus_addr(8'h00); bus_addr(8'h00);
        bus_cmd(8'hD0);
        check("R5 erase busy", rb_pull_low, 1);
        ce_n = 1'b1;
        bus_cmd(8'h70);
        ce_n = 1'b0;
        bus_read(w, oe);
        check("R10 status while busy", w, 16'h0080);
        check("R12 oe in status while busy", oe, 1);
        ce_n = 1'b1;
        bus_cmd(8'hFF);
        check("R9 reset ends busy", rb_pull_low, 0);
        check("R6 standby after ready", standby, 1);
        ce_n = 1'b0;

        bus_cmd(8'h60);
        bus_addr(8'h00); bus_addr(8'h00); bus_addr(8'h00);
        bus_cmd(8'hD0);
        wait_ready(n);
        check("R5 erase busy length", n, T_ERASE);

        // R12 R9: data mode read strobe while busy, reset during read
        bus_cmd(8'h00);
        bus_addr(8'h00); bus_addr(8'h00); bus_addr(8'h00);
        bus_cmd(8'h30);
        re_n = 1'b0;
        @(negedge clk);
        check("R12 no oe while busy", io_oe, 0);
        re_n = 1'b1;
        @(negedge clk);
        bus_cmd(8'hFF);
        check("R9 reset during read", rb_pull_low, 0);

        // R1: unknown code ignored
        bus_cmd(8'h5A);
        check("R1 unknown code no busy", rb_pull_low, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule